// File: doc/BRIEF.md
# Display PHY post-divider strobe tree

This block turns a fast VCO clock into the byte-rate and pixel-rate timing of a display PHY. It does not make new clock nets. Every stage runs on the VCO clock and emits a one-cycle enable strobe, and the next stage counts those strobes.

The chain works as follows:
- A power-of-two pre-divider feeds a one-based bit divider.
- A fixed divide-by-eight of the bit strobe gives the byte strobe.
- Fixed taps give half the bit rate and a quarter of the pre-divider rate.
- A four-way source selector picks one of four strobes. A one-based pixel divider follows the selector and gives the pixel strobe.

The bit and pixel ratios share one eight-bit configuration word. A global gate input clears both outputs. Software drops the gate before powering down the source, so downstream logic never sees a stray pulse.

Top module: `pixel_byte_clkdiv`

## Requirements
- R1: The pre-divider emits a strobe once every 2^k VCO cycles, where k is the 2-bit `pre_code` (ratios 1, 2, 4 and 8).
- R2: The bit divider takes its ratio N from `div_cfg[3:0]` and passes one of every N pre-divider strobes. A field value of 0 acts as N = 1.
- R3: `byte_stb` pulses once for every 8 bit strobes, so its period is 2^k·N·8 VCO cycles.
- R4: `pix_src` picks the pixel divider input:
  - 0 selects the bit strobe.
  - 1 selects the bit strobe divided by 2.
  - 2 selects the pre-divider strobe.
  - 3 selects the pre-divider strobe divided by 4.
- R5: The pixel divider takes its ratio M from `div_cfg[7:4]`, is one-based, and treats 0 as M = 1. The pixel period is the selected source period times M.
- R6: While `gate_en` is low, both outputs stay low. The dividers keep counting, so when the gate reopens the strobes resume on their original phase.
- R7: A new ratio on any divider is loaded only when that divider reaches its terminal count. The period in progress finishes at the old length, so no strobe interval is shortened.
- R8: During reset and for the first cycle after it, both outputs are low. Each output pulse lasts one VCO cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Global output enable; low forces both strobes low |
| pre_code | input | 2 | Power-of-two pre-divider exponent |
| div_cfg | input | 8 | [3:0] bit ratio, [7:4] pixel ratio, both one-based |
| pix_src | input | 2 | Pixel divider source select |
| byte_stb | output | 1 | One-cycle byte-rate strobe |
| pix_stb | output | 1 | One-cycle pixel-rate strobe |

## Verification
The bench builds the block with its default parameters: a 4-bit ratio field and a 2-bit pre-divider exponent. This puts every ratio code within reach, including the zero codes that alias to 1, and the longest pixel period of 8·15·2·15 = 3600 cycles. Ratio changes are made mid-period, so the reload-at-terminal-count rule shows up directly in the strobe timing. The gate is closed for an odd number of cycles, so a divider that froze while the gate was closed would come back out of phase.

// File: rtl/pixel_byte_clkdiv.sv
`timescale 1ns/1ps
module pixel_byte_clkdiv #(
  parameter int DIV_W = 4,
  parameter int PWR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_en,
  input  logic [PWR_W-1:0]   pre_code,
  input  logic [2*DIV_W-1:0] div_cfg,
  input  logic [1:0]         pix_src,
  output logic               byte_stb,
  output logic               pix_stb
);
  localparam int PRE_CW = (1 << PWR_W) - 1;

  logic              live;
  logic [PRE_CW-1:0] c_pre;
  logic [DIV_W-1:0]  c_bit, c_pix;
  logic [2:0]        c_byte;
  logic              c_half;
  logic [1:0]        c_qtr;

  logic [PRE_CW:0]   pre_ratio;
  logic [PRE_CW-1:0] pre_load;
  logic [DIV_W-1:0]  bit_n, pix_n, bit_load, pix_load;
  logic s_pre, s_bit, s_byte, s_half, s_qtr, s_mux, s_pix;

  assign pre_ratio = (PRE_CW+1)'(1) << pre_code;
  assign pre_load  = pre_ratio[PRE_CW-1:0] - PRE_CW'(1);
  assign bit_n     = div_cfg[DIV_W-1:0];
  assign pix_n     = div_cfg[2*DIV_W-1:DIV_W];
  assign bit_load  = (bit_n == '0) ? '0 : bit_n - DIV_W'(1);
  assign pix_load  = (pix_n == '0) ? '0 : pix_n - DIV_W'(1);

  assign s_pre  = live  && (c_pre  == '0);
  assign s_bit  = s_pre && (c_bit  == '0);
  assign s_byte = s_bit && (c_byte == '0);
  assign s_half = s_bit && !c_half;
  assign s_qtr  = s_pre && (c_qtr  == '0);

  always_comb begin
    case (pix_src)
      2'd0:    s_mux = s_bit;
      2'd1:    s_mux = s_half;
      2'd2:    s_mux = s_pre;
      default: s_mux = s_qtr;
    endcase
  end

  assign s_pix    = s_mux && (c_pix == '0);
  assign byte_stb = gate_en && s_byte;
  assign pix_stb  = gate_en && s_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      c_pre  <= '0;
      c_bit  <= '0;
      c_byte <= '0;
      c_half <= 1'b0;
      c_qtr  <= '0;
      c_pix  <= '0;
    end else begin
      live <= 1'b1;
      if (live)  c_pre <= (c_pre == '0) ? pre_load : c_pre - PRE_CW'(1);
      if (s_pre) c_bit <= (c_bit == '0) ? bit_load : c_bit - DIV_W'(1);
      if (s_pre) c_qtr <= c_qtr - 2'd1;
      if (s_bit) begin
        c_byte <= c_byte - 3'd1;
        c_half <= ~c_half;
      end
      if (s_mux) c_pix <= (c_pix == '0) ? pix_load : c_pix - DIV_W'(1);
    end
  end

  p_gate_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (!byte_stb && !pix_stb));

  p_byte_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);

  p_byte_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> s_bit);

  p_pix_on_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |-> s_mux);

  p_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_pre |=> $stable(c_bit));

  p_pix_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_mux |=> $stable(c_pix));

  p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (!byte_stb && !pix_stb));
endmodule

// File: tb/test_pixel_byte_clkdiv.sv
`timescale 1ns/1ps
module test_pixel_byte_clkdiv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b1;
  logic [1:0] pre_code = 2'd0;
  logic [7:0] div_cfg = 8'h11;
  logic [1:0] pix_src = 2'd0;
  logic byte_stb, pix_stb;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_byte_clkdiv i_pixel_byte_clkdiv (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .pre_code(pre_code),
    .div_cfg(div_cfg), .pix_src(pix_src), .byte_stb(byte_stb), .pix_stb(pix_stb));

  // behavioural reference: one countdown integer per divider
  int m_live, m_pre, m_bit, m_byte, m_half, m_qtr, m_pix;
  bit e_pre, e_bit, e_byte, e_half, e_qtr, e_mux, e_pix;

  function automatic int one_based(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always_comb begin
    e_pre  = (m_live != 0) && (m_pre == 0);
    e_bit  = e_pre && (m_bit == 0);
    e_byte = e_bit && (m_byte == 0);
    e_half = e_bit && (m_half == 0);
    e_qtr  = e_pre && (m_qtr == 0);
    case (pix_src)
      2'd0: e_mux = e_bit;
      2'd1: e_mux = e_half;
      2'd2: e_mux = e_pre;
      default: e_mux = e_qtr;
    endcase
    e_pix = e_mux && (m_pix == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = 0; m_pre = 0; m_bit = 0; m_byte = 0; m_half = 0; m_qtr = 0; m_pix = 0;
    end else begin
      bit p, b, x;
      p = e_pre; b = e_bit; x = e_mux;
      if (m_live != 0) m_pre = (m_pre == 0) ? (2 ** int'(pre_code)) - 1 : m_pre - 1;
      if (p) m_bit = (m_bit == 0) ? one_based(int'(div_cfg[3:0])) - 1 : m_bit - 1;
      if (p) m_qtr = (m_qtr == 0) ? 3 : m_qtr - 1;
      if (b) begin
        m_byte = (m_byte == 0) ? 7 : m_byte - 1;
        m_half = (m_half == 0) ? 1 : 0;
      end
      if (x) m_pix = (m_pix == 0) ? one_based(int'(div_cfg[7:4])) - 1 : m_pix - 1;
      m_live = 1;
    end
  end

  task automatic check_period(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s period: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Run a setting, compare every cycle, and optionally check the steady-state periods.
  task automatic run(input int p, input int bn, input int pn, input int sel, input bit g,
                     input int cycles, input string tag, input bit per_chk);
    int tb_last = -1, tp_last = -1, nb = 0, np = 0, ib = 0, ip = 0;
    int src, exp_pix;
    pre_code = 2'(p); div_cfg = 8'((pn << 4) | bn); pix_src = 2'(sel); gate_en = g;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      vectors++;
      if (byte_stb !== (g && e_byte) || pix_stb !== (g && e_pix)) begin
        errors++;
        $display("FAIL %s cycle %0d: actual byte=%b pix=%b expected byte=%b pix=%b",
                 tag, c, byte_stb, pix_stb, g && e_byte, g && e_pix);
      end
      if (byte_stb === 1'b1) begin
        if (tb_last >= 0) ib = c - tb_last;
        tb_last = c; nb++;
      end
      if (pix_stb === 1'b1) begin
        if (tp_last >= 0) ip = c - tp_last;
        tp_last = c; np++;
      end
    end
    if (per_chk) begin
      case (sel)
        0: src = (2 ** p) * one_based(bn);
        1: src = (2 ** p) * one_based(bn) * 2;
        2: src = (2 ** p);
        default: src = (2 ** p) * 4;
      endcase
      exp_pix = src * one_based(pn);
      if (nb >= 3) check_period(tag, "byte", ib, (2 ** p) * one_based(bn) * 8);
      else check_period(tag, "byte (too few pulses)", nb, 3);
      if (np >= 3) check_period(tag, "pix", ip, exp_pix);
      else check_period(tag, "pix (too few pulses)", np, 3);
    end
  endtask

  initial begin
    // R8: outputs low while reset is held
    repeat (4) begin
      @(negedge clk);
      vectors++;
      if (byte_stb !== 1'b0 || pix_stb !== 1'b0) begin
        errors++;
        $display("FAIL R8 reset: actual byte=%b pix=%b expected 0 0", byte_stb, pix_stb);
      end
    end
    rst_n = 1'b1;
    run(0, 1, 1, 2, 1'b1, 50, "R8", 1'b0);
    // R1: pre-divider power-of-two ratios seen through the pixel path
    for (int k = 0; k < 4; k++) run(k, 1, 1, 2, 1'b1, 400, "R1", 1'b1);
    // R2: one-based bit ratio, zero aliases to one
    run(0, 0, 1, 0, 1'b1, 300, "R2", 1'b1);
    run(0, 1, 1, 0, 1'b1, 300, "R2", 1'b1);
    run(0, 5, 1, 0, 1'b1, 600, "R2", 1'b1);
    run(0, 15, 1, 0, 1'b1, 800, "R2", 1'b1);
    // R3: fixed divide-by-eight byte strobe
    run(1, 3, 1, 0, 1'b1, 500, "R3", 1'b1);
    // R4: each selector code
    for (int s = 0; s < 4; s++) run(1, 3, 2, s, 1'b1, 400, "R4", 1'b1);
    // R5: one-based pixel ratio
    run(0, 1, 0, 2, 1'b1, 200, "R5", 1'b1);
    run(0, 1, 7, 2, 1'b1, 200, "R5", 1'b1);
    run(2, 3, 15, 3, 1'b1, 3000, "R5", 1'b1);
    // R6: gate closed, then phase continuity after reopening
    run(1, 3, 2, 1, 1'b1, 200, "R6", 1'b0);
    run(1, 3, 2, 1, 1'b0, 333, "R6", 1'b0);
    run(1, 3, 2, 1, 1'b1, 400, "R6", 1'b1);
    // R7: mid-period ratio changes complete the running period first
    run(3, 15, 15, 0, 1'b1, 170, "R7", 1'b0);
    run(0, 1, 1, 0, 1'b1, 400, "R7", 1'b1);
    run(2, 9, 4, 1, 1'b1, 37, "R7", 1'b0);
    run(1, 2, 3, 3, 1'b1, 600, "R7", 1'b1);
    // longest path exercises every stage at its maximum ratio
    run(3, 15, 15, 1, 1'b1, 12000, "R5", 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule